// File: doc/BRIEF.md
# Program ROM Bank Mapper

This block selects which 8 KB page of a cartridge program ROM the CPU sees in each of its upper address windows. The CPU writes bank numbers into four 8-bit bank registers and a mode byte. From the stored values the block computes, with no added latency, one ROM page index for each of the windows at 0x8000, 0xA000, 0xC000 and 0xE000. It can also compute a page index for the 0x6000 window, together with a flag that says whether that window is mapped.

The ROM page count `NUM_BANKS` is a parameter. It must be a power of two of at least 4, and every page index is reduced modulo that count. There are four arrangements of the windows: fixed top-of-ROM, a paired 16 KB mode, a direct mode, and a reversed mode. The mode byte also holds a 2-bit character-banking mode and a nametable-source bit. The block does not use these two fields itself. It passes them out unchanged for neighbouring logic.

The write port is a plain single-cycle strobe and has no back-pressure: every write with `wr_en` high at a clock edge is accepted on that edge. The page outputs are combinational functions of the stored state, so they change in the cycle after the accepting edge.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, bank register i holds (NUM_BANKS-4+i) and every mode field is zero. The windows therefore show pages NUM_BANKS-4, -3, -2, -1 in address order, `low_valid` is 0, `chr_mode` is 0 and `nt_from_rom` is 0.
- R2: When `wr_en` is high and (`wr_addr` AND 0xF007) equals 0x8000+k (k = 0..3), bank register k loads `wr_data` at the clock edge. Mirror addresses such as 0x8FF9 address the same register as 0x8001.
- R3: When `wr_en` is high and (`wr_addr` AND 0xF007) equals 0xD000, the mode byte is stored. Its fields are: bit 7 enables the 0x6000 window, bit 2 makes the top window switchable, bits 1:0 select the program mode, bits 4:3 appear on `chr_mode`, and bit 5 appears on `nt_from_rom`.
- R4: Program mode 0 shows pages NUM_BANKS-4, -3, -2, -1 in windows 0..3, whatever the register contents.
- R5: Program mode 1 shows page 2*reg1 in window 0 and page 2*reg1+1 in window 1. Windows 2 and 3 show pages NUM_BANKS-2 and NUM_BANKS-1.
- R6: Program mode 2 with bit 2 set shows reg0..reg3 in windows 0..3.
- R7: Program mode 2 with bit 2 clear shows reg0..reg2 in windows 0..2 and page NUM_BANKS-1 in window 3. If bit 7 is also set, the 0x6000 window shows reg3.
- R8: Program mode 3 shows reg3, reg2, reg1, reg0 in windows 0..3.
- R9: `low_valid` is 1 exactly when the mode is 2, bit 2 is clear and bit 7 is set. Whenever `low_valid` is 0, `low_bank` is 0.
- R10: Writes whose masked address is neither 0x8000..0x8003 nor 0xD000 (for example 0x8004, 0x9000, 0xD001, 0x6000) change no output. Cycles with `wr_en` low also change no output.
- R11: Every page output equals the selected value modulo NUM_BANKS, that is, its low log2(NUM_BANKS) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| win0_bank | output | log2(NUM_BANKS) | Page for window 0x8000 |
| win1_bank | output | log2(NUM_BANKS) | Page for window 0xA000 |
| win2_bank | output | log2(NUM_BANKS) | Page for window 0xC000 |
| win3_bank | output | log2(NUM_BANKS) | Page for window 0xE000 |
| low_bank | output | log2(NUM_BANKS) | Page for window 0x6000, 0 when unmapped |
| low_valid | output | 1 | 0x6000 window is mapped |
| chr_mode | output | 2 | Stored character-banking mode field |
| nt_from_rom | output | 1 | Stored nametable-source field |

## Verification
The hardest state to reach from the ports is the 0x6000 window being mapped while register 3 holds a value that differs from everything else on the outputs. This needs mode 2, bit 2 clear and bit 7 set all at once, after register 3 has been loaded while a different mode was active. The bench reaches it by loading distinct register patterns first and then sweeping all 256 mode bytes. After each mode byte it compares every window, the low window and its flag against an arithmetic model. A separate sweep writes every data value through mirror addresses into each register, and the reversed mode makes each write visible on a window.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

  typedef enum logic [1:0] {
    PM_FIXED   = 2'd0,
    PM_PAIR16  = 2'd1,
    PM_DIRECT  = 2'd2,
    PM_REVERSE = 2'd3
  } prg_mode_e;

  typedef struct packed {
    logic      low_en;
    logic      nt_rom;
    logic [1:0] chr_mode;
    logic      top_sw;
    prg_mode_e pmode;
  } mode_cfg_t;

  localparam logic [15:0] DEC_MASK  = 16'hF007;
  localparam logic [15:0] PRG_BASE  = 16'h8000;
  localparam logic [15:0] MODE_ADDR = 16'hD000;
  localparam int          WIN_CNT   = 4;

  function automatic mode_cfg_t unpack_mode(input logic [7:0] d);
    mode_cfg_t m;
    m.low_en   = d[7];
    m.nt_rom   = d[5];
    m.chr_mode = d[4:3];
    m.top_sw   = d[2];
    m.pmode    = prg_mode_e'(d[1:0]);
    return m;
  endfunction

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_bank_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int REG_CNT = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [REG_CNT-1:0] reg_we,
  output logic              mode_we
);
  logic [ADDR_W-1:0] masked;

  always_comb masked = wr_addr & ADDR_W'(DEC_MASK);

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg_dec
    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(PRG_BASE) | ADDR_W'(i);
    always_comb reg_we[i] = wr_en && (masked == HIT);
  end

  always_comb mode_we = wr_en && (masked == ADDR_W'(MODE_ADDR));
endmodule

// File: rtl/prg_reg_file.sv
module prg_reg_file
  import prg_bank_pkg::*;
#(
  parameter int NUM_BANKS = 64,
  parameter int REG_CNT   = 4,
  parameter int DATA_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [REG_CNT-1:0]        reg_we,
  input  logic                      mode_we,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [REG_CNT*DATA_W-1:0] regs_flat,
  output mode_cfg_t                 mode_cfg
);
  for (genvar i = 0; i < REG_CNT; i++) begin : g_bank_reg
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(NUM_BANKS - REG_CNT + i);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= RST_VAL;
      else if (reg_we[i]) q <= wr_data;
    end
    always_comb regs_flat[i*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_cfg <= '0;
    else if (mode_we) mode_cfg <= unpack_mode(wr_data[7:0]);
  end
endmodule

// File: rtl/prg_bank_calc.sv
module prg_bank_calc
  import prg_bank_pkg::*;
#(
  parameter int NUM_BANKS = 64,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic [WIN_CNT*DATA_W-1:0] regs_flat,
  input  mode_cfg_t                 mode_cfg,
  output logic [WIN_CNT*BANK_W-1:0] win_flat,
  output logic [BANK_W-1:0]         low_bank,
  output logic                      low_valid
);
  localparam logic [BANK_W-1:0] LAST = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] r [WIN_CNT];
  logic [BANK_W-1:0] top_page [WIN_CNT];

  for (genvar i = 0; i < WIN_CNT; i++) begin : g_slice
    always_comb r[i] = regs_flat[i*DATA_W +: BANK_W];
    always_comb top_page[i] = BANK_W'(NUM_BANKS - WIN_CNT + i);
  end

  for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
    logic [BANK_W-1:0] pg;
    always_comb begin
      unique case (mode_cfg.pmode)
        PM_FIXED:   pg = top_page[w];
        PM_PAIR16:  pg = (w < 2) ? {r[1][BANK_W-2:0], 1'(w)} : top_page[w];
        PM_DIRECT:  pg = (mode_cfg.top_sw || w < WIN_CNT - 1) ? r[w] : LAST;
        PM_REVERSE: pg = r[WIN_CNT-1-w];
        default:    pg = top_page[w];
      endcase
    end
    always_comb win_flat[w*BANK_W +: BANK_W] = pg;
  end

  always_comb begin
    low_valid = (mode_cfg.pmode == PM_DIRECT) && !mode_cfg.top_sw && mode_cfg.low_en;
    low_bank  = low_valid ? r[WIN_CNT-1] : '0;
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_bank_pkg::*;
#(
  parameter int NUM_BANKS = 64,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BANK_W-1:0] win0_bank,
  output logic [BANK_W-1:0] win1_bank,
  output logic [BANK_W-1:0] win2_bank,
  output logic [BANK_W-1:0] win3_bank,
  output logic [BANK_W-1:0] low_bank,
  output logic              low_valid,
  output logic [1:0]        chr_mode,
  output logic              nt_from_rom
);
  logic [WIN_CNT-1:0]        reg_we;
  logic                      mode_we;
  logic [WIN_CNT*DATA_W-1:0] regs_flat;
  mode_cfg_t                 mode_cfg;
  logic [WIN_CNT*BANK_W-1:0] win_flat;

  prg_wr_decode #(.ADDR_W(ADDR_W), .REG_CNT(WIN_CNT)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .reg_we(reg_we), .mode_we(mode_we)
  );

  prg_reg_file #(.NUM_BANKS(NUM_BANKS), .REG_CNT(WIN_CNT), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mode_we(mode_we),
    .wr_data(wr_data), .regs_flat(regs_flat), .mode_cfg(mode_cfg)
  );

  prg_bank_calc #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_calc (
    .regs_flat(regs_flat), .mode_cfg(mode_cfg), .win_flat(win_flat),
    .low_bank(low_bank), .low_valid(low_valid)
  );

  always_comb begin
    win0_bank   = win_flat[0*BANK_W +: BANK_W];
    win1_bank   = win_flat[1*BANK_W +: BANK_W];
    win2_bank   = win_flat[2*BANK_W +: BANK_W];
    win3_bank   = win_flat[3*BANK_W +: BANK_W];
    chr_mode    = mode_cfg.chr_mode;
    nt_from_rom = mode_cfg.nt_rom;
  end
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int NUM_BANKS = 64,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [BANK_W-1:0] win0_bank,
  input logic [BANK_W-1:0] win1_bank,
  input logic [BANK_W-1:0] win2_bank,
  input logic [BANK_W-1:0] win3_bank,
  input logic [BANK_W-1:0] low_bank,
  input logic              low_valid,
  input logic [1:0]        chr_mode,
  input logic              nt_from_rom
);
  localparam logic [BANK_W-1:0] P4 = BANK_W'(NUM_BANKS - 4);
  localparam logic [BANK_W-1:0] P3 = BANK_W'(NUM_BANKS - 3);
  localparam logic [BANK_W-1:0] P2 = BANK_W'(NUM_BANKS - 2);
  localparam logic [BANK_W-1:0] P1 = BANK_W'(NUM_BANKS - 1);

  logic [ADDR_W-1:0] m_addr;
  logic mode_wr, prg_wr, dead_wr;
  always_comb begin
    m_addr  = wr_addr & ADDR_W'(16'hF007);
    mode_wr = wr_en && m_addr == ADDR_W'(16'hD000);
    prg_wr  = wr_en && m_addr[ADDR_W-1:2] == ADDR_W'(16'h8000) >> 2;
    dead_wr = !mode_wr && !prg_wr;
  end

  p_fixed_pages_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && wr_data[1:0] == 2'd0 |=>
      win0_bank == P4 && win1_bank == P3 && win2_bank == P2 && win3_bank == P1);

  p_pair_pages_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && wr_data[1:0] == 2'd1 |=>
      win0_bank[0] == 1'b0 && win1_bank == win0_bank + 1'b1 &&
      win2_bank == P2 && win3_bank == P1);

  p_low_top_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_valid |-> win3_bank == P1);

  p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !low_valid |-> low_bank == '0);

  p_dead_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dead_wr |=> $stable(win0_bank) && $stable(win1_bank) && $stable(win2_bank) &&
                $stable(win3_bank) && $stable(low_bank) && $stable(low_valid) &&
                $stable(chr_mode) && $stable(nt_from_rom));

  p_mode_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> chr_mode == $past(wr_data[4:3]) && nt_from_rom == $past(wr_data[5]));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .win0_bank(win0_bank), .win1_bank(win1_bank), .win2_bank(win2_bank),
  .win3_bank(win3_bank), .low_bank(low_bank), .low_valid(low_valid),
  .chr_mode(chr_mode), .nt_from_rom(nt_from_rom)
);

// File: tb/sim_prg_bank_mapper.sv
`timescale 1ns/1ps
module sim_prg_bank_mapper;
  localparam int N  = 16;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [BW-1:0] win0_bank, win1_bank, win2_bank, win3_bank, low_bank;
  logic low_valid, nt_from_rom;
  logic [1:0] chr_mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [4];
  logic [7:0] m_mode;

  always #5 clk = ~clk;

  prg_bank_mapper #(.NUM_BANKS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win0_bank(win0_bank), .win1_bank(win1_bank), .win2_bank(win2_bank),
    .win3_bank(win3_bank), .low_bank(low_bank), .low_valid(low_valid),
    .chr_mode(chr_mode), .nt_from_rom(nt_from_rom)
  );

  task automatic chk(input string req, input string what, input integer act, input integer exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic integer exp_win(input int w);
    int v;
    case (m_mode[1:0])
      2'd0: v = N - 4 + w;
      2'd1: v = (w < 2) ? m_reg[1] * 2 + w : N - 4 + w;
      2'd2: v = (m_mode[2] || w < 3) ? int'(m_reg[w]) : N - 1;
      default: v = m_reg[3 - w];
    endcase
    return v % N;
  endfunction

  function automatic bit exp_lv();
    return m_mode[1:0] == 2'd2 && !m_mode[2] && m_mode[7];
  endfunction

  function automatic string mode_req();
    case (m_mode[1:0])
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return m_mode[2] ? "R6" : "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_all(input string req);
    string r;
    r = (req == "") ? mode_req() : req;
    chk(r, "win0", win0_bank, exp_win(0));
    chk(r, "win1", win1_bank, exp_win(1));
    chk(r, "win2", win2_bank, exp_win(2));
    chk(r, "win3", win3_bank, exp_win(3));
    chk("R9", "low_valid", low_valid, exp_lv());
    chk("R9", "low_bank", low_bank, exp_lv() ? (m_reg[3] % N) : 0);
    chk("R3", "chr_mode", chr_mode, m_mode[4:3]);
    chk("R3", "nt_from_rom", nt_from_rom, m_mode[5]);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_reg(input int k, input logic [15:0] mirror, input logic [7:0] d);
    wr(16'h8000 | (mirror & 16'h0FF8) | 16'(k), d);
    m_reg[k] = d;
  endtask

  task automatic wr_mode(input logic [15:0] a, input logic [7:0] d);
    wr(a, d);
    m_mode = d;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 8'(N - 4 + i);
    m_mode = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_all("R1");

    // R2: direct register loads through the base addresses, seen in reversed mode (R8)
    wr_mode(16'hD000, 8'h03);
    wr_reg(0, 16'h0000, 8'h21);
    wr_reg(1, 16'h0000, 8'h37);
    wr_reg(2, 16'h0000, 8'h4A);
    wr_reg(3, 16'h0000, 8'h5C);
    check_all("R2");

    // R3: exhaustive sweep of the mode byte over two register patterns
    for (int p = 0; p < 2; p++) begin
      if (p == 1) begin
        wr_reg(0, 16'h0FF8, 8'hE3);
        wr_reg(1, 16'h0120, 8'h06);
        wr_reg(2, 16'h0A08, 8'h9D);
        wr_reg(3, 16'h07F0, 8'h7B);
      end
      for (int m = 0; m < 256; m++) begin
        wr_mode(16'hD000, 8'(m));
        check_all("");
      end
    end

    // R3: a mirror of the mode address is decoded as the mode register
    wr_mode(16'hDFF8, 8'h3A);
    check_all("R3");

    // R2, R11: every data value into every register through mirrors, reversed mode
    wr_mode(16'hD000, 8'h03);
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 256; v++) begin
        wr_reg(k, 16'((v * 8) & 16'h0FF8), 8'(v));
        chk("R11", "reversed window tracks written value",
            (k == 0) ? win3_bank : (k == 1) ? win2_bank : (k == 2) ? win1_bank : win0_bank,
            v % N);
      end
    end

    // R5: paired mode over every value of register 1
    wr_mode(16'hD000, 8'h01);
    for (int v = 0; v < 256; v++) begin
      wr_reg(1, 16'h0000, 8'(v));
      chk("R5", "pair low", win0_bank, (v * 2) % N);
      chk("R5", "pair high", win1_bank, (v * 2 + 1) % N);
    end

    // R10: undecoded addresses and idle strobes change nothing
    wr_mode(16'hD000, 8'h03);
    wr_reg(0, 16'h0, 8'h01); wr_reg(1, 16'h0, 8'h02);
    wr_reg(2, 16'h0, 8'h05); wr_reg(3, 16'h0, 8'h09);
    begin
      logic [15:0] dead [10];
      dead = '{16'h8004, 16'h8007, 16'h9000, 16'hA001, 16'hB003,
               16'hC005, 16'hD001, 16'hD004, 16'hE000, 16'h6000};
      for (int i = 0; i < 10; i++) begin
        wr(dead[i], 8'h00);
        check_all("R10");
        wr(dead[i], 8'hB6);
        check_all("R10");
      end
    end
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 16'hD000; wr_data = 8'h00;
    @(negedge clk);
    wr_addr = 16'h8002; wr_data = 8'hFF;
    @(negedge clk);
    check_all("R10");

    // R7, R9: low window maps register 3 then is unmapped again
    wr_mode(16'hD000, 8'h82);
    wr_reg(3, 16'h0, 8'h0E);
    check_all("R7");
    wr_mode(16'hD000, 8'h86);
    check_all("R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule